// File: doc/BRIEF.md
# Dual-Register Phase Accumulator Front End

This block is the clocked input stage that sits ahead of a coordinate converter. It captures a magnitude (or X) word and a phase (or Y) word. The phase word feeds two registers: a carrier increment register and a modulation offset register. A two-bit control code, sampled every cycle, decides for each of the two registers whether it holds, loads or clears.

In accumulate mode a 32-bit running phase grows by the carrier increment on every clock and wraps modulo 2^32. The phase result is the top 16 bits of that running phase plus the modulation offset. In direct mode the accumulator stays at zero. The carrier register then takes only the upper half of the phase word, and the phase result is that upper half plus the offset.

Both results are registered. Each one has an active-high disable input. While a disable is high, its output word reads zero and its valid flag is low, in place of a high-impedance drive. The stage accepts a new input every cycle and has no back-pressure: the results are a fixed pipeline, and a downstream stage that cannot take a word must use the valid flag or the disable to ignore it. The coordinate conversion itself sits outside this block.

Top module: `pa_front`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the captured magnitude, both control registers, the running phase and the phase result all become zero, so both outputs read zero when enabled.
- R2: The magnitude register takes `mag_i` at a rising edge when `mag_en_i` is 1 and keeps its value when it is 0. `mag_o` shows the register directly, so a captured word appears one edge after it is presented.
- R3: Code `ph_code_i` = 2'b00 leaves both the carrier and the modulation registers unchanged.
- R4: Code 2'b01 loads the modulation register with `ph_i[31:16]` and leaves the carrier register unchanged.
- R5: Code 2'b10 loads the carrier register and leaves the modulation register unchanged.
- R6: Code 2'b11 clears the modulation register to zero and loads the carrier register.
- R7: With `acc_mode_i` = 1, the carrier register loads all 32 bits of `ph_i`. At each edge the running phase becomes its old value plus the old carrier value, modulo 2^32, and `ph_o` becomes the old running phase bits [31:16] plus the old modulation value, modulo 2^16.
- R8: With `acc_mode_i` = 0, the carrier register loads `{ph_i[31:16], 16'h0}`, so `ph_i[15:0]` has no effect. The running phase is cleared at each edge, and `ph_o` becomes the old carrier bits [31:16] plus the old modulation value, modulo 2^16.
- R9: When `mag_dis_i` is high, `mag_o` is zero and `mag_vld_o` is 0 in the same cycle. When `ph_dis_i` is high, the same holds for `ph_o` and `ph_vld_o`. When a disable is low, its valid flag is 1 and its output shows the registered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| mag_en_i | input | 1 | Capture enable for the magnitude word |
| mag_i | input | 16 | Magnitude / X input word |
| ph_code_i | input | 2 | Register action code for the carrier and modulation registers |
| ph_i | input | 32 | Phase / Y input word, bit 31 the MSB |
| acc_mode_i | input | 1 | 1 = accumulate mode, 0 = direct mode |
| mag_dis_i | input | 1 | Disable for the magnitude output, active high |
| ph_dis_i | input | 1 | Disable for the phase output, active high |
| mag_o | output | 16 | Registered magnitude, zero while disabled |
| mag_vld_o | output | 1 | High while the magnitude output is enabled |
| ph_o | output | 16 | Registered phase result, zero while disabled |
| ph_vld_o | output | 1 | High while the phase output is enabled |

## Verification
A captured magnitude appears one edge after it is presented. A word loaded into the carrier or modulation register first reaches `ph_o` two edges after it is presented. In accumulate mode a new carrier value is added into the running phase one edge after it is loaded, and it first shows on `ph_o` one edge after that. The disables act in the same cycle they are driven. The bench drives inputs on the falling edge and advances a reference model by exactly one edge for each input set. It then compares every output on the next falling edge, so each result is judged in the cycle it is due. The directed wrap case and the lower-bits case use fixed expected words counted out on those same edges.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    PA_HOLD   = 2'b00,
    PA_LD_MOD = 2'b01,
    PA_LD_CAR = 2'b10,
    PA_CLR_LD = 2'b11
  } pa_code_e;
endpackage

// File: rtl/pa_in_regs.sv
module pa_in_regs
  import pa_pkg::*;
#(
  parameter int MAG_W = 16,
  parameter int PH_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mag_en_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [1:0]       ph_code_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             acc_mode_i,
  output logic [MAG_W-1:0] mag_q,
  output logic [PH_W-1:0]  car_q,
  output logic [OUT_W-1:0] mod_q
);
  localparam int LO_W = PH_W - OUT_W;

  pa_code_e         code;
  logic [PH_W-1:0]  car_ld;
  logic [OUT_W-1:0] ph_hi;

  assign code   = pa_code_e'(ph_code_i);
  assign ph_hi  = ph_i[PH_W-1 -: OUT_W];
  assign car_ld = acc_mode_i ? ph_i : {ph_hi, {LO_W{1'b0}}};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mag_q <= '0;
    end else if (mag_en_i) begin
      mag_q <= mag_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      car_q <= '0;
      mod_q <= '0;
    end else begin
      unique case (code)
        PA_HOLD:   ;
        PA_LD_MOD: mod_q <= ph_hi;
        PA_LD_CAR: car_q <= car_ld;
        PA_CLR_LD: begin
          car_q <= car_ld;
          mod_q <= '0;
        end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
  parameter int PH_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_mode_i,
  input  logic [PH_W-1:0]  car_q,
  input  logic [OUT_W-1:0] mod_q,
  output logic [PH_W-1:0]  acc_q,
  output logic [OUT_W-1:0] ph_q
);
  logic [OUT_W-1:0] base;

  assign base = acc_mode_i ? acc_q[PH_W-1 -: OUT_W] : car_q[PH_W-1 -: OUT_W];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else begin
      acc_q <= acc_mode_i ? acc_q + car_q : '0;
      ph_q  <= base + mod_q;
    end
  end
endmodule

// File: rtl/pa_out_gate.sv
module pa_out_gate #(
  parameter int W = 16
) (
  input  logic         dis_i,
  input  logic [W-1:0] data_q,
  output logic [W-1:0] data_o,
  output logic         vld_o
);
  assign vld_o  = ~dis_i;
  assign data_o = dis_i ? '0 : data_q;
endmodule

// File: rtl/pa_front.sv
module pa_front #(
  parameter int MAG_W = 16,
  parameter int PH_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mag_en_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [1:0]       ph_code_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             acc_mode_i,
  input  logic             mag_dis_i,
  input  logic             ph_dis_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             mag_vld_o,
  output logic [OUT_W-1:0] ph_o,
  output logic             ph_vld_o
);
  logic [MAG_W-1:0] mag_q;
  logic [PH_W-1:0]  car_q;
  logic [OUT_W-1:0] mod_q;
  logic [PH_W-1:0]  acc_q;
  logic [OUT_W-1:0] ph_q;

  pa_in_regs #(.MAG_W(MAG_W), .PH_W(PH_W), .OUT_W(OUT_W)) in_regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mag_en_i   (mag_en_i),
    .mag_i      (mag_i),
    .ph_code_i  (ph_code_i),
    .ph_i       (ph_i),
    .acc_mode_i (acc_mode_i),
    .mag_q      (mag_q),
    .car_q      (car_q),
    .mod_q      (mod_q)
  );

  pa_accum #(.PH_W(PH_W), .OUT_W(OUT_W)) accum_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_mode_i (acc_mode_i),
    .car_q      (car_q),
    .mod_q      (mod_q),
    .acc_q      (acc_q),
    .ph_q       (ph_q)
  );

  pa_out_gate #(.W(MAG_W)) mag_gate_i (
    .dis_i  (mag_dis_i),
    .data_q (mag_q),
    .data_o (mag_o),
    .vld_o  (mag_vld_o)
  );

  pa_out_gate #(.W(OUT_W)) ph_gate_i (
    .dis_i  (ph_dis_i),
    .data_q (ph_q),
    .data_o (ph_o),
    .vld_o  (ph_vld_o)
  );
endmodule

// File: rtl/pa_front_chk.sv
module pa_front_chk #(
  parameter int MAG_W = 16,
  parameter int PH_W  = 32,
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mag_en_i,
  input logic [MAG_W-1:0] mag_i,
  input logic [1:0]       ph_code_i,
  input logic [PH_W-1:0]  ph_i,
  input logic             acc_mode_i,
  input logic             mag_dis_i,
  input logic             ph_dis_i,
  input logic [MAG_W-1:0] mag_o,
  input logic             mag_vld_o,
  input logic [OUT_W-1:0] ph_o,
  input logic             ph_vld_o,
  input logic [PH_W-1:0]  car_q,
  input logic [OUT_W-1:0] mod_q,
  input logic [PH_W-1:0]  acc_q
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> (car_q == '0 && mod_q == '0 && acc_q == '0));

  a_r2_mag_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_en_i && !mag_dis_i) ##1 !mag_dis_i |-> mag_o == $past(mag_i));

  a_r3_hold_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_code_i == 2'b00 |=> $stable(car_q) && $stable(mod_q));

  a_r4_load_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_code_i == 2'b01 |=> $stable(car_q) && mod_q == $past(ph_i[PH_W-1 -: OUT_W]));

  a_r5_load_car: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_code_i == 2'b10 |=> $stable(mod_q));

  a_r6_clear_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_code_i == 2'b11 |=> mod_q == '0);

  a_r7_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_mode_i |=> acc_q == $past(acc_q) + $past(car_q));

  a_r8_direct_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_mode_i |=> acc_q == '0);

  a_r9_mag_masked: assert property (@(posedge clk_i)
    mag_dis_i |-> (!mag_vld_o && mag_o == '0));

  a_r9_ph_masked: assert property (@(posedge clk_i)
    ph_dis_i |-> (!ph_vld_o && ph_o == '0));
endmodule

bind pa_front pa_front_chk #(.MAG_W(MAG_W), .PH_W(PH_W), .OUT_W(OUT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mag_en_i   (mag_en_i),
  .mag_i      (mag_i),
  .ph_code_i  (ph_code_i),
  .ph_i       (ph_i),
  .acc_mode_i (acc_mode_i),
  .mag_dis_i  (mag_dis_i),
  .ph_dis_i   (ph_dis_i),
  .mag_o      (mag_o),
  .mag_vld_o  (mag_vld_o),
  .ph_o       (ph_o),
  .ph_vld_o   (ph_vld_o),
  .car_q      (car_q),
  .mod_q      (mod_q),
  .acc_q      (acc_q)
);

// File: tb/pa_front_tb_top.sv
module pa_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mag_en;
  logic [15:0] mag_in;
  logic [1:0]  code;
  logic [31:0] ph_in;
  logic        acc_mode;
  logic        mag_dis;
  logic        ph_dis;
  logic [15:0] mag_out;
  logic        mag_vld;
  logic [15:0] ph_out;
  logic        ph_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model state
  logic [15:0] m_mag, m_mod, m_ph;
  logic [31:0] m_car, m_acc;
  string       tag_hist [2];

  always #5 clk = ~clk;

  pa_front dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mag_en_i   (mag_en),
    .mag_i      (mag_in),
    .ph_code_i  (code),
    .ph_i       (ph_in),
    .acc_mode_i (acc_mode),
    .mag_dis_i  (mag_dis),
    .ph_dis_i   (ph_dis),
    .mag_o      (mag_out),
    .mag_vld_o  (mag_vld),
    .ph_o       (ph_out),
    .ph_vld_o   (ph_vld)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string code_tag(logic [1:0] c, logic mode);
    case (c)
      2'b01:   return "R4";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return mode ? "R7" : "R3";
    endcase
  endfunction

  // model advances by one edge using the inputs now being driven
  task automatic model_step();
    logic [15:0] base;
    logic [31:0] car_ld;
    if (!rst_n) begin
      m_mag = '0; m_mod = '0; m_ph = '0; m_car = '0; m_acc = '0;
      return;
    end
    base   = acc_mode ? m_acc[31:16] : m_car[31:16];
    car_ld = acc_mode ? ph_in : {ph_in[31:16], 16'h0};
    m_ph   = base + m_mod;
    m_acc  = acc_mode ? m_acc + m_car : 32'h0;
    if (mag_en) m_mag = mag_in;
    case (code)
      2'b01: m_mod = ph_in[31:16];
      2'b10: m_car = car_ld;
      2'b11: begin m_car = car_ld; m_mod = '0; end
      default: ;
    endcase
  endtask

  task automatic cyc();
    string t;
    t = rst_n ? code_tag(code, acc_mode) : "R1";
    model_step();
    @(posedge clk);
    @(negedge clk);
    tag_hist[1] = tag_hist[0];
    tag_hist[0] = t;
    check(rst_n ? "R2" : "R1", {16'h0, mag_out}, {16'h0, mag_dis ? 16'h0 : m_mag});
    check(tag_hist[1], {16'h0, ph_out}, {16'h0, ph_dis ? 16'h0 : m_ph});
    check("R9", {30'h0, mag_vld, ph_vld}, {30'h0, ~mag_dis, ~ph_dis});
  endtask

  task automatic drive(logic en, logic [15:0] m, logic [1:0] c, logic [31:0] p);
    mag_en = en; mag_in = m; code = c; ph_in = p;
  endtask

  initial begin
    tag_hist[0] = "R1"; tag_hist[1] = "R1";
    rst_n = 1'b0; acc_mode = 1'b1; mag_dis = 1'b0; ph_dis = 1'b0;
    drive(1'b1, 16'hFFFF, 2'b11, 32'hFFFF_FFFF);
    repeat (2) cyc();
    check("R1", {mag_out, ph_out}, 32'h0);

    // R2: load then hold
    rst_n = 1'b1;
    drive(1'b1, 16'h5A5A, 2'b00, 32'h0);
    cyc();
    check("R2", {16'h0, mag_out}, 32'h5A5A);
    drive(1'b0, 16'h1111, 2'b00, 32'h0);
    cyc();
    check("R2", {16'h0, mag_out}, 32'h5A5A);

    // R7: accumulator wrap at 2^32
    rst_n = 1'b0; cyc();
    rst_n = 1'b1; acc_mode = 1'b1;
    drive(1'b0, 16'h0, 2'b10, 32'hC000_0000);
    cyc();
    drive(1'b0, 16'h0, 2'b00, 32'h0);
    cyc(); cyc();
    check("R7", {16'h0, ph_out}, 32'hC000);
    cyc();
    check("R7", {16'h0, ph_out}, 32'h8000);

    // R8: direct mode ignores low half of the phase word
    rst_n = 1'b0; cyc();
    rst_n = 1'b1; acc_mode = 1'b0;
    drive(1'b0, 16'h0, 2'b10, 32'hABCD_1234);
    cyc();
    drive(1'b0, 16'h0, 2'b00, 32'h0);
    cyc();
    check("R8", {16'h0, ph_out}, 32'hABCD);
    drive(1'b0, 16'h0, 2'b10, 32'hABCD_FFFF);
    cyc();
    drive(1'b0, 16'h0, 2'b00, 32'h0);
    cyc();
    check("R8", {16'h0, ph_out}, 32'hABCD);

    // R4 then R6: offset added, then cleared while carrier reloads
    drive(1'b0, 16'h0, 2'b01, 32'h0010_7777);
    cyc();
    drive(1'b0, 16'h0, 2'b00, 32'h0);
    cyc();
    check("R4", {16'h0, ph_out}, 32'hABDD);
    drive(1'b0, 16'h0, 2'b11, 32'h0100_0000);
    cyc();
    drive(1'b0, 16'h0, 2'b00, 32'hFFFF_FFFF);
    cyc();
    check("R6", {16'h0, ph_out}, 32'h0100);
    cyc();
    check("R3", {16'h0, ph_out}, 32'h0100);

    // R9: disables act in the same cycle
    mag_dis = 1'b1; ph_dis = 1'b1;
    #1;
    check("R9", {mag_out, ph_out}, 32'h0);
    check("R9", {30'h0, mag_vld, ph_vld}, 32'h0);
    mag_dis = 1'b0; ph_dis = 1'b0;

    // constrained random
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      rst_n    = ($urandom_range(0, 199) != 0);
      if ($urandom_range(0, 49) == 0) acc_mode = ~acc_mode;
      mag_dis  = ($urandom_range(0, 7) == 0);
      ph_dis   = ($urandom_range(0, 7) == 0);
      drive(1'($urandom_range(0, 1)), 16'($urandom), 2'($urandom_range(0, 3)), $urandom);
      cyc();
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule